// File: doc/BRIEF.md
# Transactional Undo-Log Version Manager

This block sits beside one processor's cache and handles version management for hardware transactions. New values are written in place by the cache, and the block saves the old value of each block to an undo log in memory. It counts transaction nesting. It keeps one read bit and one write bit for each cache line and holds a log base, a log bound and a log pointer. The first transactional store to a block in a transaction sends that block's address and its old 64-byte contents to the log write port.

A commit is cheap. When the outermost transaction commits, the pointer returns to the base and every read and write bit clears in a single cycle. An abort costs more. The block walks the log from the pointer back to the base, newest entry first, and hands each saved address and old value to a write-back stream so memory can be restored. It then resets its transaction state. Software sets the base and bound while no transaction is open.

Two interfaces use valid/ready handshakes. On the access stream, the block holds `acc_ready` low while an append it needs has not been accepted by the log write port, and it holds it low for the whole abort walk. On the undo stream, the block keeps an entry on `undo_va`/`undo_data` until `undo_ready` is seen at a clock edge. The log write port takes one entry in each cycle where valid and ready are both high. Commands, faults and flags are plain single-cycle pins.

Top module: `undo_log_mgr`

## Requirements
- R1: `cmd_begin` raises `nest_depth` by one. `ckpt_pulse` is high for the single cycle after a begin that found the depth at zero, and it stays low for nested begins.
- R2: `cmd_commit` lowers the depth by one. When it lowers the depth from one to zero, the same edge returns `log_ptr` to the base, clears every read and write bit, and raises `ovf_clear` for one cycle. An inner commit leaves the pointer and bits unchanged.
- R3: A transactional store to a line in state M whose write bit is clear presents one log entry. The entry is written to `log_wr_addr` equal to `log_ptr`, with the access address and old data, and the line's write bit is set on acceptance. A store to a line whose write bit is already set appends nothing.
- R4: Each accepted append advances `log_ptr` by 72 (0x48): 8 address bytes plus 64 data bytes. A base of 0x1000 therefore moves to 0x1048 and then to 0x1090.
- R5: State codes on `acc_state` are I=0, S=1, E=2, O=3, M=4. A transactional load sets its line's read bit only when the state is not I. A write bit is set only by an access in state M. A store in any other state is accepted and has no effect.
- R6: `cmd_abort` starts a walk. The walk reads entries at pointer-72, pointer-144 and so on down to the base, and emits each on the undo stream newest first, lowering `log_ptr` by 72 per accepted entry. At the end, `abort_done` pulses, the depth is zero, the pointer is at the base, all bits are clear and `ovf_clear` pulses.
- R7: An access in state M with `acc_refetch` set, which marks a block refetched under a sticky owner state, appends an entry even if the write bit is already set. On acceptance it sets both the read and the write bit.
- R8: If an append would end past the bound (pointer + 72 > bound), nothing is written. `log_fault` pulses for one cycle, the access is accepted, and the pointer and write bit are unchanged.
- R9: While an append is pending and `log_wr_ready` is low, `acc_ready` is low and `log_ptr` does not move.
- R10: A commit or abort at depth zero, or any command during the abort walk, is ignored. It raises `cmd_err` for one cycle and the depth is unchanged.
- R11: Accesses outside a transaction are accepted and ignored: no append, and no bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load base and bound (taken only with no open transaction) |
| init_base | input | PTR_W | Log base byte address |
| init_bound | input | PTR_W | Log end byte address (exclusive) |
| cmd_begin | input | 1 | Begin transaction |
| cmd_commit | input | 1 | Commit transaction |
| cmd_abort | input | 1 | Abort transaction |
| acc_valid | input | 1 | Access event valid |
| acc_ready | output | 1 | Access event accepted |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_refetch | input | 1 | Block refetched under a sticky owner state |
| acc_line | input | LINE_W | Cache line index |
| acc_state | input | 3 | Coherence state of the line |
| acc_va | input | VA_W | Block virtual address |
| acc_old_data | input | DATA_W | Old block contents |
| log_wr_valid | output | 1 | Log entry write valid |
| log_wr_ready | input | 1 | Log write port ready |
| log_wr_addr | output | PTR_W | Log entry byte address |
| log_wr_va | output | VA_W | Logged address |
| log_wr_data | output | DATA_W | Logged old data |
| log_rd_en | output | 1 | Log read request (data expected next cycle) |
| log_rd_addr | output | PTR_W | Log read byte address |
| log_rd_va | input | VA_W | Read-back address |
| log_rd_data | input | DATA_W | Read-back old data |
| undo_valid | output | 1 | Restore entry valid |
| undo_ready | input | 1 | Restore entry accepted |
| undo_va | output | VA_W | Address to restore |
| undo_data | output | DATA_W | Value to restore |
| nest_depth | output | NEST_W | Current nesting depth |
| log_ptr | output | PTR_W | Current log pointer |
| line_rbits | output | LINES | Per-line read bits |
| line_wbits | output | LINES | Per-line write bits |
| ckpt_pulse | output | 1 | Register checkpoint request |
| log_fault | output | 1 | Log bound exceeded |
| ovf_clear | output | 1 | Reset request for the cache overflow bit |
| abort_done | output | 1 | Abort walk finished |
| cmd_err | output | 1 | Illegal command ignored |

## Verification
The checker tests these rules on every cycle:
- the checkpoint pulse matches a zero-to-one depth step;
- every flush leaves the pointer at the base with all bits clear;
- each append moves the pointer up by 72 and each undo hand-off moves it down by 72;
- no append ever crosses the bound;
- a new write bit only follows an access in state M;
- a stalled append always holds the access stream.

The bench scenarios cover what spans many cycles:
- the newest-first order and contents of the undo stream;
- the one-append-per-block rule and the refetch exception;
- the sweep of all five coherence states;
- ignored commands at depth zero.

// File: rtl/undo_log_pkg.sv
package undo_log_pkg;
  typedef enum logic [1:0] {WK_RUN, WK_RD, WK_CAP, WK_WB} walk_e;
  localparam logic [2:0] LS_I = 3'd0;
  localparam logic [2:0] LS_S = 3'd1;
  localparam logic [2:0] LS_E = 3'd2;
  localparam logic [2:0] LS_O = 3'd3;
  localparam logic [2:0] LS_M = 3'd4;
  localparam int ADDR_SLOT_BYTES = 8;
endpackage

// File: rtl/undo_nest.sv
module undo_nest #(
  parameter int NEST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              busy_i,
  input  logic              walk_done_i,
  output logic [NEST_W-1:0] depth_o,
  output logic              ckpt_o,
  output logic              outer_commit_o,
  output logic              abort_go_o,
  output logic              err_o
);
  localparam logic [NEST_W-1:0] DEPTH_MAX = '1;

  logic [NEST_W-1:0] depth_q;
  logic multi, any_cmd, ok_begin, ok_commit, ok_abort;

  always_comb begin
    any_cmd   = begin_i | commit_i | abort_i;
    multi     = (begin_i & commit_i) | (begin_i & abort_i) | (commit_i & abort_i);
    ok_begin  = begin_i  & ~multi & ~busy_i & (depth_q != DEPTH_MAX);
    ok_commit = commit_i & ~multi & ~busy_i & (depth_q != '0);
    ok_abort  = abort_i  & ~multi & ~busy_i & (depth_q != '0);
  end

  assign outer_commit_o = ok_commit & (depth_q == NEST_W'(1));
  assign abort_go_o     = ok_abort;
  assign depth_o        = depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      ckpt_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (walk_done_i)    depth_q <= '0;
      else if (ok_begin)  depth_q <= depth_q + NEST_W'(1);
      else if (ok_commit) depth_q <= depth_q - NEST_W'(1);
      ckpt_o <= ok_begin & (depth_q == '0);
      err_o  <= any_cmd & ~(ok_begin | ok_commit | ok_abort);
    end
  end
endmodule

// File: rtl/undo_rwbits.sv
module undo_rwbits #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              set_r_i,
  input  logic              set_w_i,
  output logic [LINES-1:0]  rbits_o,
  output logic [LINES-1:0]  wbits_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit;
    assign hit = (line_i == LINE_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
        rbits_o[g] <= 1'b0;
        wbits_o[g] <= 1'b0;
      end else begin
        if (set_r_i && hit) rbits_o[g] <= 1'b1;
        if (set_w_i && hit) wbits_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/undo_log_mgr.sv
module undo_log_mgr
  import undo_log_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int VA_W   = 64,
  parameter int DATA_W = 512,
  parameter int PTR_W  = 32,
  parameter int NEST_W = 4,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_valid,
  input  logic [PTR_W-1:0]  init_base,
  input  logic [PTR_W-1:0]  init_bound,
  input  logic              cmd_begin,
  input  logic              cmd_commit,
  input  logic              cmd_abort,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_store,
  input  logic              acc_refetch,
  input  logic [LINE_W-1:0] acc_line,
  input  logic [2:0]        acc_state,
  input  logic [VA_W-1:0]   acc_va,
  input  logic [DATA_W-1:0] acc_old_data,
  output logic              log_wr_valid,
  input  logic              log_wr_ready,
  output logic [PTR_W-1:0]  log_wr_addr,
  output logic [VA_W-1:0]   log_wr_va,
  output logic [DATA_W-1:0] log_wr_data,
  output logic              log_rd_en,
  output logic [PTR_W-1:0]  log_rd_addr,
  input  logic [VA_W-1:0]   log_rd_va,
  input  logic [DATA_W-1:0] log_rd_data,
  output logic              undo_valid,
  input  logic              undo_ready,
  output logic [VA_W-1:0]   undo_va,
  output logic [DATA_W-1:0] undo_data,
  output logic [NEST_W-1:0] nest_depth,
  output logic [PTR_W-1:0]  log_ptr,
  output logic [LINES-1:0]  line_rbits,
  output logic [LINES-1:0]  line_wbits,
  output logic              ckpt_pulse,
  output logic              log_fault,
  output logic              ovf_clear,
  output logic              abort_done,
  output logic              cmd_err
);
  localparam int ENTRY_BYTES = ADDR_SLOT_BYTES + DATA_W / 8;
  localparam logic [PTR_W-1:0] ENTRY = PTR_W'(ENTRY_BYTES);

  walk_e             st_q;
  logic [PTR_W-1:0]  base_q, bound_q, ptr_q;
  logic [VA_W-1:0]   cap_va_q;
  logic [DATA_W-1:0] cap_data_q;

  logic run, in_tx, take, is_m, valid_st, need_app, room;
  logic fault_now, app_done, hs, set_r, set_w, walk_done, clear_bits;
  logic outer_commit, abort_go;

  undo_nest #(.NEST_W(NEST_W)) u_nest (
    .clk(clk), .rst_n(rst_n),
    .begin_i(cmd_begin), .commit_i(cmd_commit), .abort_i(cmd_abort),
    .busy_i(!run), .walk_done_i(walk_done),
    .depth_o(nest_depth), .ckpt_o(ckpt_pulse),
    .outer_commit_o(outer_commit), .abort_go_o(abort_go), .err_o(cmd_err)
  );

  undo_rwbits #(.LINES(LINES), .LINE_W(LINE_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_bits),
    .line_i(acc_line), .set_r_i(set_r), .set_w_i(set_w),
    .rbits_o(line_rbits), .wbits_o(line_wbits)
  );

  always_comb begin
    run      = (st_q == WK_RUN);
    in_tx    = (nest_depth != '0);
    take     = acc_valid & run & in_tx;
    is_m     = (acc_state == LS_M);
    valid_st = (acc_state != LS_I);
    need_app = take & is_m & (acc_refetch | (acc_store & ~line_wbits[acc_line]));
    room     = ({1'b0, ptr_q} + {1'b0, ENTRY}) <= {1'b0, bound_q};
    log_wr_valid = need_app & room;
    fault_now    = need_app & ~room;
    acc_ready    = run & (~log_wr_valid | log_wr_ready);
    hs           = acc_valid & acc_ready;
    app_done     = log_wr_valid & log_wr_ready;
    set_w        = app_done;
    set_r        = hs & take & valid_st & (~acc_store | (acc_refetch & app_done));
    walk_done    = (st_q == WK_RD) & (ptr_q == base_q);
    clear_bits   = outer_commit | walk_done;
    log_rd_en    = (st_q == WK_RD) & (ptr_q != base_q);
    undo_valid   = (st_q == WK_WB);
  end

  assign log_wr_addr = ptr_q;
  assign log_wr_va   = acc_va;
  assign log_wr_data = acc_old_data;
  assign log_rd_addr = ptr_q - ENTRY;
  assign undo_va     = cap_va_q;
  assign undo_data   = cap_data_q;
  assign log_ptr     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= WK_RUN;
      base_q     <= '0;
      bound_q    <= '0;
      ptr_q      <= '0;
      cap_va_q   <= '0;
      cap_data_q <= '0;
      log_fault  <= 1'b0;
      ovf_clear  <= 1'b0;
      abort_done <= 1'b0;
    end else begin
      log_fault  <= fault_now;
      ovf_clear  <= clear_bits;
      abort_done <= walk_done;
      unique case (st_q)
        WK_RUN: begin
          if (init_valid && !in_tx) begin
            base_q  <= init_base;
            bound_q <= init_bound;
            ptr_q   <= init_base;
          end else if (outer_commit) begin
            ptr_q <= base_q;
          end else if (app_done) begin
            ptr_q <= ptr_q + ENTRY;
          end
          if (abort_go) st_q <= WK_RD;
        end
        WK_RD:  st_q <= walk_done ? WK_RUN : WK_CAP;
        WK_CAP: begin
          cap_va_q   <= log_rd_va;
          cap_data_q <= log_rd_data;
          st_q       <= WK_WB;
        end
        WK_WB: begin
          if (undo_ready) begin
            ptr_q <= ptr_q - ENTRY;
            st_q  <= WK_RD;
          end
        end
        default: st_q <= WK_RUN;
      endcase
    end
  end
endmodule

// File: rtl/undo_log_mgr_chk.sv
module undo_log_mgr_chk #(
  parameter int LINES  = 16,
  parameter int PTR_W  = 32,
  parameter int NEST_W = 4,
  parameter int ENTRY_BYTES = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [2:0]        acc_state,
  input logic              log_wr_valid,
  input logic              log_wr_ready,
  input logic [PTR_W-1:0]  log_wr_addr,
  input logic              undo_valid,
  input logic              undo_ready,
  input logic [NEST_W-1:0] nest_depth,
  input logic [PTR_W-1:0]  log_ptr,
  input logic [LINES-1:0]  line_rbits,
  input logic [LINES-1:0]  line_wbits,
  input logic              ckpt_pulse,
  input logic              ovf_clear,
  input logic [PTR_W-1:0]  log_base,
  input logic [PTR_W-1:0]  log_bound
);
  localparam logic [PTR_W-1:0] ENT = PTR_W'(ENTRY_BYTES);

  p_ckpt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_pulse |-> (nest_depth == NEST_W'(1)) && ($past(nest_depth) == '0));

  p_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |-> (log_ptr == log_base) && (line_rbits == '0) && (line_wbits == '0) && (nest_depth == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr_valid && log_wr_ready) |=> (log_ptr == $past(log_ptr) + ENT));

  p_wbit_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_wbits & ~$past(line_wbits)) != '0) |-> $past(acc_valid && acc_state == 3'd4));

  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_valid && undo_ready) |=> (log_ptr == $past(log_ptr) - ENT));

  p_walk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    undo_valid |-> !acc_ready);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    log_wr_valid |-> ({1'b0, log_wr_addr} + {1'b0, ENT}) <= {1'b0, log_bound});

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr_valid && !log_wr_ready) |-> !acc_ready);
endmodule

bind undo_log_mgr undo_log_mgr_chk #(
  .LINES(LINES), .PTR_W(PTR_W), .NEST_W(NEST_W), .ENTRY_BYTES(ENTRY_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_state(acc_state), .log_wr_valid(log_wr_valid), .log_wr_ready(log_wr_ready),
  .log_wr_addr(log_wr_addr), .undo_valid(undo_valid), .undo_ready(undo_ready),
  .nest_depth(nest_depth), .log_ptr(log_ptr), .line_rbits(line_rbits),
  .line_wbits(line_wbits), .ckpt_pulse(ckpt_pulse), .ovf_clear(ovf_clear),
  .log_base(base_q), .log_bound(bound_q)
);

// File: tb/undo_log_mgr_tb.sv
module undo_log_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int LW    = 2;
  localparam int VA_W  = 64;
  localparam int DW    = 512;
  localparam int PW    = 32;
  localparam int NW    = 2;
  localparam int ENT   = 72;
  localparam logic [PW-1:0] BASE = 32'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_valid = 0, cmd_begin = 0, cmd_commit = 0, cmd_abort = 0;
  logic [PW-1:0] init_base = '0, init_bound = '0;
  logic acc_valid = 0, acc_store = 0, acc_refetch = 0, acc_ready;
  logic [LW-1:0] acc_line = '0;
  logic [2:0] acc_state = '0;
  logic [VA_W-1:0] acc_va = '0;
  logic [DW-1:0] acc_old_data = '0;
  logic log_wr_valid, log_wr_ready = 1'b1, log_rd_en, undo_valid, undo_ready = 1'b1;
  logic [PW-1:0] log_wr_addr, log_rd_addr, log_ptr;
  logic [VA_W-1:0] log_wr_va, undo_va, rd_va = '0;
  logic [DW-1:0] log_wr_data, undo_data, rd_data = '0;
  logic [NW-1:0] nest_depth;
  logic [LINES-1:0] line_rbits, line_wbits;
  logic ckpt_pulse, log_fault, ovf_clear, abort_done, cmd_err;

  undo_log_mgr #(.LINES(LINES), .VA_W(VA_W), .DATA_W(DW), .PTR_W(PW), .NEST_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_base(init_base),
    .init_bound(init_bound), .cmd_begin(cmd_begin), .cmd_commit(cmd_commit),
    .cmd_abort(cmd_abort), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_store(acc_store), .acc_refetch(acc_refetch), .acc_line(acc_line),
    .acc_state(acc_state), .acc_va(acc_va), .acc_old_data(acc_old_data),
    .log_wr_valid(log_wr_valid), .log_wr_ready(log_wr_ready), .log_wr_addr(log_wr_addr),
    .log_wr_va(log_wr_va), .log_wr_data(log_wr_data), .log_rd_en(log_rd_en),
    .log_rd_addr(log_rd_addr), .log_rd_va(rd_va), .log_rd_data(rd_data),
    .undo_valid(undo_valid), .undo_ready(undo_ready), .undo_va(undo_va),
    .undo_data(undo_data), .nest_depth(nest_depth), .log_ptr(log_ptr),
    .line_rbits(line_rbits), .line_wbits(line_wbits), .ckpt_pulse(ckpt_pulse),
    .log_fault(log_fault), .ovf_clear(ovf_clear), .abort_done(abort_done), .cmd_err(cmd_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [VA_W-1:0] mva [8];
  logic [DW-1:0]   mdat [8];
  logic [VA_W-1:0] uva [8];
  logic [DW-1:0]   udat [8];
  int nwr = 0, nun = 0, total = 0, fails = 0;

  always @(posedge clk) begin
    if (log_wr_valid && log_wr_ready) begin
      mva[((log_wr_addr - BASE) / ENT) % 8]  <= log_wr_va;
      mdat[((log_wr_addr - BASE) / ENT) % 8] <= log_wr_data;
      nwr <= nwr + 1;
    end
    if (log_rd_en) begin
      rd_va   <= mva[((log_rd_addr - BASE) / ENT) % 8];
      rd_data <= mdat[((log_rd_addr - BASE) / ENT) % 8];
    end
    if (undo_valid && undo_ready) begin
      uva[nun % 8]  <= undo_va;
      udat[nun % 8] <= undo_data;
      nun <= nun + 1;
    end
  end

  function automatic logic [DW-1:0] mkd(input int k);
    return {16{32'(k) ^ 32'h5a5a0000}};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic b, input logic c, input logic a);
    @(negedge clk);
    cmd_begin = b; cmd_commit = c; cmd_abort = a;
    @(negedge clk);
    cmd_begin = 0; cmd_commit = 0; cmd_abort = 0;
    #1;
  endtask

  task automatic access(input logic st, input int line, input logic [VA_W-1:0] va,
                        input logic [DW-1:0] d, input logic [2:0] cs, input logic rf);
    @(negedge clk);
    acc_valid = 1; acc_store = st; acc_line = LW'(line); acc_va = va;
    acc_old_data = d; acc_state = cs; acc_refetch = rf;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    acc_valid = 0; acc_refetch = 0;
    #1;
  endtask

  task automatic wait_abort();
    while (!abort_done) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset depth", 64'(nest_depth), 0);
    chk("R2 reset wbits", 64'(line_wbits), 0);
    chk("R1 reset ckpt", 64'(ckpt_pulse), 0);

    // R10: commit/abort at depth zero
    cmd(0, 1, 0);
    chk("R10 commit@0 err", 64'(cmd_err), 1);
    chk("R10 commit@0 depth", 64'(nest_depth), 0);
    cmd(0, 0, 1);
    chk("R10 abort@0 err", 64'(cmd_err), 1);
    chk("R10 abort@0 depth", 64'(nest_depth), 0);

    @(negedge clk);
    init_valid = 1; init_base = BASE; init_bound = BASE + 32'(3 * ENT);
    @(negedge clk); init_valid = 0; #1;
    chk("R4 ptr at base", 64'(log_ptr), 64'(BASE));

    // R11: store outside transaction
    access(1, 0, 64'h40, mkd(1), 3'd4, 0);
    chk("R11 no append", 64'(nwr), 0);
    chk("R11 no wbit", 64'(line_wbits), 0);

    // R1: nesting and checkpoint
    @(negedge clk); cmd_begin = 1; @(negedge clk); cmd_begin = 0; #1;
    chk("R1 ckpt outer", 64'(ckpt_pulse), 1);
    chk("R1 depth 1", 64'(nest_depth), 1);
    @(negedge clk); #1;
    chk("R1 ckpt single", 64'(ckpt_pulse), 0);
    cmd(1, 0, 0);
    chk("R1 ckpt nested", 64'(ckpt_pulse), 0);
    chk("R1 depth 2", 64'(nest_depth), 2);

    // R3/R4: first store appends, later store does not
    access(1, 2, 64'hc0, mkd(2), 3'd4, 0);
    chk("R3 append count", 64'(nwr), 1);
    chk("R3 log va", mva[0], 64'hc0);
    chk("R3 log data", 64'(mdat[0][63:0]), 64'(mkd(2)));
    chk("R3 wbit set", 64'(line_wbits[2]), 1);
    chk("R4 ptr 0x1048", 64'(log_ptr), 64'h1048);
    access(1, 2, 64'hc0, mkd(9), 3'd4, 0);
    chk("R3 no second append", 64'(nwr), 1);

    // R9: back-pressure
    log_wr_ready = 0;
    @(negedge clk);
    acc_valid = 1; acc_store = 1; acc_line = 2'd3; acc_va = 64'h100; acc_old_data = mkd(3); acc_state = 3'd4;
    #1;
    chk("R9 stall ready", 64'(acc_ready), 0);
    chk("R9 wr valid", 64'(log_wr_valid), 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 ptr held", 64'(log_ptr), 64'h1048);
    chk("R9 still stalled", 64'(acc_ready), 0);
    log_wr_ready = 1;
    @(negedge clk); acc_valid = 0; #1;
    chk("R4 ptr 0x1090", 64'(log_ptr), 64'h1090);

    // R2: inner then outer commit
    cmd(0, 1, 0);
    chk("R2 inner ptr", 64'(log_ptr), 64'h1090);
    chk("R2 inner bits", 64'(line_wbits), 64'b1100);
    chk("R2 inner no clear", 64'(ovf_clear), 0);
    cmd(0, 1, 0);
    chk("R2 outer ptr", 64'(log_ptr), 64'(BASE));
    chk("R2 outer bits", 64'(line_wbits), 0);
    chk("R2 ovf_clear", 64'(ovf_clear), 1);
    chk("R2 depth 0", 64'(nest_depth), 0);

    // R5: sweep all coherence states
    for (int s = 0; s < 5; s++) begin
      cmd(1, 0, 0);
      access(0, 0, 64'h0, mkd(0), 3'(s), 0);
      chk("R5 rbit by state", 64'(line_rbits[0]), (s != 0) ? 1 : 0);
      access(1, 1, 64'h80, mkd(s), 3'(s), 0);
      chk("R5 wbit by state", 64'(line_wbits[1]), (s == 4) ? 1 : 0);
      chk("R5 ptr by state", 64'(log_ptr), 64'(BASE) + ((s == 4) ? ENT : 0));
      cmd(0, 1, 0);
    end

    // R8 and R6: fill log, fault, then abort walk
    nwr = 0;
    cmd(1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      access(1, i, 64'(32'h200 + i * 64), mkd(10 + i), 3'd4, 0);
      if (i == 3) begin
        chk("R8 fault pulse", 64'(log_fault), 1);
        chk("R8 ptr at bound", 64'(log_ptr), 64'(BASE) + 3 * ENT);
        chk("R8 wbit not set", 64'(line_wbits[3]), 0);
      end
    end
    chk("R8 three appends", 64'(nwr), 3);
    nun = 0;
    cmd(0, 0, 1);
    wait_abort();
    chk("R6 pop count", 64'(nun), 3);
    for (int k = 0; k < 3; k++) begin
      chk("R6 lifo va", uva[k], 64'(32'h200 + (2 - k) * 64));
      chk("R6 lifo data", 64'(udat[k][63:0]), 64'(mkd(12 - k)));
    end
    chk("R6 depth reset", 64'(nest_depth), 0);
    chk("R6 ptr reset", 64'(log_ptr), 64'(BASE));
    chk("R6 bits reset", 64'({line_rbits, line_wbits}), 0);
    chk("R6 ovf_clear", 64'(ovf_clear), 1);

    // R7: sticky refetch appends again and sets both bits
    nwr = 0; nun = 0;
    cmd(1, 0, 0);
    access(1, 0, 64'h300, mkd(20), 3'd4, 0);
    access(1, 0, 64'h300, mkd(21), 3'd4, 1);
    chk("R7 two appends", 64'(nwr), 2);
    chk("R7 ptr", 64'(log_ptr), 64'(BASE) + 2 * ENT);
    chk("R7 rbit", 64'(line_rbits[0]), 1);
    chk("R7 wbit", 64'(line_wbits[0]), 1);
    undo_ready = 0;
    cmd(0, 0, 1);
    cmd(1, 0, 0);
    chk("R10 cmd during walk", 64'(cmd_err), 1);
    repeat (4) @(negedge clk);
    undo_ready = 1;
    wait_abort();
    chk("R6 refetch pops", 64'(nun), 2);
    chk("R6 newest first", 64'(udat[0][63:0]), 64'(mkd(21)));
    chk("R6 oldest last", 64'(udat[1][63:0]), 64'(mkd(20)));
    chk("R6 depth after", 64'(nest_depth), 0);

    summary();
    $finish;
  end
endmodule